// File: doc/BRIEF.md
# Cascaded Programmable Interval Timers

This block holds three interval timers that share one tick. The tick is taken from the master clock through a fixed multiplier and a divider input, so one tick falls every TICK_MULT × divider clocks. Timer 0 is a plain down-counter that steps on every tick. A base prescaler also steps on every tick. Its expiries, not the ticks, drive two cascaded timers: a short timer 1 and a wide timer 2. The cascade gives long intervals from narrow counters.

Software loads the reload values and a control byte through a byte-wide write port. The control byte holds a run bit for each of the four counters and an interrupt mask bit for each of the three timers. Every timer reloads itself when it reaches zero and sets a sticky status flag. A status read returns all flags and clears them in the same access. The interrupt line is raised while any unmasked flag is set. A counter decrements through wrap-around, so a reload value of zero gives the longest period that counter has.

Top module: `casc_timer`

## Requirements
- R1: After reset all counters, reload registers, control bits and status flags are zero, so the status byte and the interrupt output read 0.
- R2: A tick occurs once every TICK_MULT × div_i clocks (a divider of 0 acts as 1), and every counter steps only on a tick.
- R3: When control bit 0 is set, timer 0 decrements once per tick. On the tick that brings it to zero it reloads from {register 2, register 1} (low T0_W bits) and sets status bit 4.
- R4: When control bit 3 is set, the base prescaler decrements once per tick. Its reload is {register 4 bits 3:0, register 3} (low BASE_W bits), and register 4's nibble supplies the upper bits.
- R5: Timer 1 decrements only on a base prescaler expiry while control bit 1 is set. It reloads from register 4 bits 7:4 and sets status bit 5 on expiry.
- R6: Timer 2 decrements only on a base prescaler expiry while control bit 2 is set. It reloads from {register 6, register 5} (low T2_W bits) and sets status bit 6 on expiry.
- R7: A reload value of zero gives the full period: 2^W steps for a W-bit counter. For timer 1 this is 16 base expiries.
- R8: A counter whose run bit is clear holds its value and never expires. Timers 1 and 2 do not advance while the base prescaler is stopped.
- R9: Control bits 6:4 mask timers 2..0, where a 1 blocks that timer. irq_o is the OR over the timers of (status flag AND NOT mask), and the mask leaves the flag itself untouched.
- R10: The status byte shows the flags in bits 6:4 and zero elsewhere. A status read returns the flags, and they are all clear from the next clock on.
- R11: If an expiry lands in the same clock as a status read, that timer's flag stays set.
- R12: A write to a reload register does not disturb a running count. The new value is used at that counter's next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_i | input | DIV_W | Tick divider; 0 acts as 1 |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register select: 0 control, 1/2 timer 0 low/high, 3 base low, 4 timer 1 (7:4) and base high (3:0), 5/6 timer 2 low/high, 7 unused |
| wr_data_i | input | 8 | Write data |
| stat_rd_i | input | 1 | Status read strobe; clears the flags at the clock edge |
| stat_o | output | 8 | Status byte: bit 4 timer 0, bit 5 timer 1, bit 6 timer 2 |
| irq_o | output | 1 | Interrupt request |

## Verification
An expiry is registered at the clock edge that carries the final tick, so its status bit shows from the next cycle. The bench samples every output on the falling edge and stamps each flag's first appearance with a cycle count. Expected gaps between consecutive expiries of one timer are exact whole-clock numbers (reload × base reload × TICK_MULT × divider), which the bench computes and queues in advance. The first expiry after a reset is only a timing reference. Clears and interrupt changes are due one cycle after the read or control write that causes them, and the same-cycle read race is set up by counting clocks from a known expiry.

// File: rtl/casc_timer_pkg.sv
package casc_timer_pkg;

   localparam int unsigned NUM_TMR  = 3;
   localparam int unsigned REG_AW   = 3;
   localparam int unsigned STAT_LSB = 4;

   typedef enum logic [REG_AW-1:0] {
      REG_CTRL    = 3'd0,
      REG_T0_LO   = 3'd1,
      REG_T0_HI   = 3'd2,
      REG_BASE_LO = 3'd3,
      REG_T1_MIX  = 3'd4,
      REG_T2_LO   = 3'd5,
      REG_T2_HI   = 3'd6,
      REG_SPARE   = 3'd7
   } reg_sel_e;

   // bit 0..2 run timers, bit 3 runs the base prescaler, bits 4..6 mask irqs
   typedef struct packed {
      logic [NUM_TMR-1:0] mask;
      logic               run_base;
      logic [NUM_TMR-1:0] run;
   } ctrl_t;

   localparam int unsigned CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/casc_tick_gen.sv
module casc_tick_gen #(
   parameter int unsigned MULT  = 32,
   parameter int unsigned DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_i,
   output logic             tick_o
);

   localparam int unsigned LIM_W = DIV_W + $clog2(MULT) + 1;

   if (MULT < 1) begin : g_bad_mult
      $error("casc_tick_gen: MULT must be at least 1");
   end

   logic [DIV_W-1:0] eff_div;
   logic [LIM_W-1:0] lim;
   logic [LIM_W-1:0] pc_q;

   always_comb begin
      eff_div = (div_i == '0) ? DIV_W'(1) : div_i;
      lim     = LIM_W'(eff_div) * LIM_W'(MULT);
   end

   // >= keeps the counter bounded if the divider shrinks mid-count
   assign tick_o = (pc_q >= (lim - LIM_W'(1)));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q <= '0;
      end else if (tick_o) begin
         pc_q <= '0;
      end else begin
         pc_q <= pc_q + LIM_W'(1);
      end
   end

endmodule

// File: rtl/casc_down_cnt.sv
module casc_down_cnt #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step_i,
   input  logic [W-1:0] reload_i,
   output logic         expire_o
);

   logic [W-1:0] cnt_q;

   // reaching zero on this step is an expiry; zero itself wraps to all-ones
   assign expire_o = step_i && (cnt_q == W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (step_i) begin
         cnt_q <= (cnt_q == W'(1)) ? reload_i : (cnt_q - W'(1));
      end
   end

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !step_i |=> $stable(cnt_q)); // R8

   AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !expire_o) |=> (cnt_q == $past(cnt_q) - W'(1))); // R7

   AST_EXPIRE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      expire_o |=> (cnt_q == $past(reload_i))); // R3

endmodule

// File: rtl/casc_regs.sv
module casc_regs
   import casc_timer_pkg::*;
#(
   parameter int unsigned T0_W   = 16,
   parameter int unsigned BASE_W = 12,
   parameter int unsigned T1_W   = 4,
   parameter int unsigned T2_W   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [REG_AW-1:0] wr_addr_i,
   input  logic [7:0]        wr_data_i,
   output ctrl_t             ctrl_o,
   output logic [T0_W-1:0]   t0_rld_o,
   output logic [BASE_W-1:0] base_rld_o,
   output logic [T1_W-1:0]   t1_rld_o,
   output logic [T2_W-1:0]   t2_rld_o
);

   ctrl_t      ctrl_q;
   logic [7:0] t0_lo_q, t0_hi_q, base_lo_q, mix_q, t2_lo_q, t2_hi_q;

   logic [15:0] t0_full, t2_full;
   logic [11:0] base_full;
   logic [3:0]  t1_full;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q    <= '0;
         t0_lo_q   <= '0;
         t0_hi_q   <= '0;
         base_lo_q <= '0;
         mix_q     <= '0;
         t2_lo_q   <= '0;
         t2_hi_q   <= '0;
      end else if (wr_en_i) begin
         unique case (reg_sel_e'(wr_addr_i))
            REG_CTRL:    ctrl_q    <= ctrl_t'(wr_data_i[CTRL_W-1:0]);
            REG_T0_LO:   t0_lo_q   <= wr_data_i;
            REG_T0_HI:   t0_hi_q   <= wr_data_i;
            REG_BASE_LO: base_lo_q <= wr_data_i;
            REG_T1_MIX:  mix_q     <= wr_data_i;
            REG_T2_LO:   t2_lo_q   <= wr_data_i;
            REG_T2_HI:   t2_hi_q   <= wr_data_i;
            REG_SPARE:   ;
            default:     ;
         endcase
      end
   end

   always_comb begin
      t0_full   = {t0_hi_q, t0_lo_q};
      t2_full   = {t2_hi_q, t2_lo_q};
      base_full = {mix_q[3:0], base_lo_q};
      t1_full   = mix_q[7:4];
   end

   assign ctrl_o     = ctrl_q;
   assign t0_rld_o   = t0_full[T0_W-1:0];
   assign base_rld_o = base_full[BASE_W-1:0];
   assign t1_rld_o   = t1_full[T1_W-1:0];
   assign t2_rld_o   = t2_full[T2_W-1:0];

endmodule

// File: rtl/casc_status.sv
module casc_status #(
   parameter int unsigned N       = 3,
   parameter bit          IRQ_REG = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] mask_i,
   input  logic         rd_i,
   output logic [N-1:0] flags_o,
   output logic         irq_o
);

   logic [N-1:0] flags_q;
   logic         irq_now;

   for (genvar i = 0; i < N; i++) begin : g_flag
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            flags_q[i] <= 1'b0;
         end else if (set_i[i]) begin
            flags_q[i] <= 1'b1;
         end else if (rd_i) begin
            flags_q[i] <= 1'b0;
         end
      end
   end

   assign irq_now = |(flags_q & ~mask_i);
   assign flags_o = flags_q;

   if (IRQ_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            irq_q <= 1'b0;
         end else begin
            irq_q <= irq_now;
         end
      end
      assign irq_o = irq_q;
   end else begin : g_irq_comb
      assign irq_o = irq_now;
   end

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i != '0) |=> ((flags_q & $past(set_i)) == $past(set_i))); // R11

   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && (set_i == '0)) |=> (flags_q == '0)); // R10

   AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_i |=> ((flags_q & $past(flags_q)) == $past(flags_q))); // R10

endmodule

// File: rtl/casc_timer.sv
module casc_timer
   import casc_timer_pkg::*;
#(
   parameter int unsigned TICK_MULT = 32,
   parameter int unsigned DIV_W     = 8,
   parameter int unsigned T0_W      = 16,
   parameter int unsigned BASE_W    = 12,
   parameter int unsigned T1_W      = 4,
   parameter int unsigned T2_W      = 16,
   parameter bit          IRQ_REG   = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_i,
   input  logic             wr_en_i,
   input  logic [2:0]       wr_addr_i,
   input  logic [7:0]       wr_data_i,
   input  logic             stat_rd_i,
   output logic [7:0]       stat_o,
   output logic             irq_o
);

   if (T0_W < 1 || T0_W > 16) begin : g_bad_t0
      $error("casc_timer: T0_W must lie in 1..16");
   end
   if (BASE_W < 1 || BASE_W > 12) begin : g_bad_base
      $error("casc_timer: BASE_W must lie in 1..12");
   end
   if (T1_W < 1 || T1_W > 4) begin : g_bad_t1
      $error("casc_timer: T1_W must lie in 1..4");
   end
   if (T2_W < 1 || T2_W > 16) begin : g_bad_t2
      $error("casc_timer: T2_W must lie in 1..16");
   end
   if (DIV_W < 1) begin : g_bad_div
      $error("casc_timer: DIV_W must be at least 1");
   end

   ctrl_t               ctrl;
   logic [T0_W-1:0]     t0_rld;
   logic [BASE_W-1:0]   base_rld;
   logic [T1_W-1:0]     t1_rld;
   logic [T2_W-1:0]     t2_rld;
   logic                tick;
   logic                base_exp;
   logic [NUM_TMR-1:0]  tmr_exp;
   logic [NUM_TMR-1:0]  flags;

   casc_tick_gen #(
      .MULT  (TICK_MULT),
      .DIV_W (DIV_W)
   ) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .div_i  (div_i),
      .tick_o (tick)
   );

   casc_regs #(
      .T0_W   (T0_W),
      .BASE_W (BASE_W),
      .T1_W   (T1_W),
      .T2_W   (T2_W)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en_i    (wr_en_i),
      .wr_addr_i  (wr_addr_i),
      .wr_data_i  (wr_data_i),
      .ctrl_o     (ctrl),
      .t0_rld_o   (t0_rld),
      .base_rld_o (base_rld),
      .t1_rld_o   (t1_rld),
      .t2_rld_o   (t2_rld)
   );

   casc_down_cnt #(.W(T0_W)) u_t0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .step_i   (tick && ctrl.run[0]),
      .reload_i (t0_rld),
      .expire_o (tmr_exp[0])
   );

   casc_down_cnt #(.W(BASE_W)) u_base (
      .clk      (clk),
      .rst_n    (rst_n),
      .step_i   (tick && ctrl.run_base),
      .reload_i (base_rld),
      .expire_o (base_exp)
   );

   casc_down_cnt #(.W(T1_W)) u_t1 (
      .clk      (clk),
      .rst_n    (rst_n),
      .step_i   (base_exp && ctrl.run[1]),
      .reload_i (t1_rld),
      .expire_o (tmr_exp[1])
   );

   casc_down_cnt #(.W(T2_W)) u_t2 (
      .clk      (clk),
      .rst_n    (rst_n),
      .step_i   (base_exp && ctrl.run[2]),
      .reload_i (t2_rld),
      .expire_o (tmr_exp[2])
   );

   casc_status #(
      .N       (NUM_TMR),
      .IRQ_REG (IRQ_REG)
   ) u_stat (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (tmr_exp),
      .mask_i  (ctrl.mask),
      .rd_i    (stat_rd_i),
      .flags_o (flags),
      .irq_o   (irq_o)
   );

   assign stat_o = {1'b0, flags, 4'b0000};

   AST_CASCADE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl.run_base |-> (tmr_exp[2:1] == 2'b00)); // R8

endmodule

// File: tb/casc_timer_bench.sv
module casc_timer_bench;

   localparam int MULT = 2;
   localparam int DW   = 4;
   localparam int W0   = 10;
   localparam int WB   = 9;
   localparam int W1   = 4;
   localparam int W2   = 9;

   typedef struct {
      int    gap;
      string req;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [DW-1:0] div = 4'd3;
   logic          wr_en = 1'b0;
   logic [2:0]    wr_addr = 3'd0;
   logic [7:0]    wr_data = 8'd0;
   logic          mon_rd = 1'b0;
   logic          man_rd = 1'b0;
   logic          stat_rd;
   logic [7:0]    stat;
   logic          irq;

   int n_chk  = 0;
   int n_fail = 0;
   int cyc    = 0;
   int last [3];
   int rises [3];
   bit auto_clr = 1'b1;
   exp_t q0 [$];
   exp_t q1 [$];
   exp_t q2 [$];

   assign stat_rd = mon_rd | man_rd;

   always #2 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   casc_timer #(
      .TICK_MULT (MULT),
      .DIV_W     (DW),
      .T0_W      (W0),
      .BASE_W    (WB),
      .T1_W      (W1),
      .T2_W      (W2)
   ) u_casc_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .div_i     (div),
      .wr_en_i   (wr_en),
      .wr_addr_i (wr_addr),
      .wr_data_i (wr_data),
      .stat_rd_i (stat_rd),
      .stat_o    (stat),
      .irq_o     (irq)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   task automatic push(input int t, input int gap, input string req);
      exp_t it;
      it.gap = gap;
      it.req = req;
      case (t)
         0:       q0.push_back(it);
         1:       q1.push_back(it);
         default: q2.push_back(it);
      endcase
   endtask

   function automatic int qsize(input int t);
      case (t)
         0:       return q0.size();
         1:       return q1.size();
         default: return q2.size();
      endcase
   endfunction

   task automatic pop(input int t, output exp_t it);
      case (t)
         0:       it = q0.pop_front();
         1:       it = q1.pop_front();
         default: it = q2.pop_front();
      endcase
   endtask

   // monitor: stamps each flag rise, compares gaps with the queue, clears flags
   initial begin
      forever begin
         @(negedge clk);
         if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin
               last[i]  = -1;
               rises[i] = 0;
            end
            mon_rd = 1'b0;
         end else if (auto_clr && (stat[6:4] != 3'b000)) begin
            for (int i = 0; i < 3; i++) begin
               if (stat[4+i]) begin
                  rises[i]++;
                  if (last[i] >= 0 && qsize(i) > 0) begin
                     exp_t it;
                     pop(i, it);
                     check((cyc - last[i]) == it.gap, it.req, "expiry gap",
                           cyc - last[i], it.gap);
                  end
                  last[i] = cyc;
               end
            end
            mon_rd = 1'b1;
         end else begin
            mon_rd = 1'b0;
         end
      end
   end

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_addr = a;
      wr_data = d;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic do_reset(input logic [DW-1:0] d);
      @(negedge clk);
      rst_n = 1'b0;
      div   = d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic drain();
      while (q0.size() + q1.size() + q2.size() > 0) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      wait (cyc >= 190000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_run();
   end

   initial begin
      int e;
      int t;

      // R1: reset state
      do_reset(4'd3);
      @(negedge clk);
      check(stat == 8'h00, "R1", "status after reset", stat, 0);
      check(irq == 1'b0, "R1", "irq after reset", irq, 0);

      // R8: timer 0 loaded but not running
      wr(3'd1, 8'd3);
      wr(3'd0, 8'h00);
      repeat (600) @(negedge clk);
      check(rises[0] == 0, "R8", "timer 0 expiries while stopped", rises[0], 0);
      check(stat == 8'h00, "R8", "status while stopped", stat, 0);

      // R3: reload 3, tick = 2*3 clocks -> 18 clocks per expiry
      push(0, 18, "R3");
      push(0, 18, "R3");
      push(0, 18, "R3");
      wr(3'd0, 8'h01);
      drain();

      // R12: new reload {1,2}=258 only after the running interval
      push(0, 18, "R12");
      push(0, 258 * 6, "R12");
      wr(3'd1, 8'h02);
      wr(3'd2, 8'h01);
      drain();

      // R7: zero reload on timer 0 -> 1024 ticks
      push(0, 258 * 6, "R7");
      push(0, 1024 * 6, "R7");
      wr(3'd1, 8'h00);
      wr(3'd2, 8'h00);
      drain();

      // R2: divider 1 -> tick every 2 clocks, reload 5 -> 10 clocks
      do_reset(4'd1);
      push(0, 10, "R2");
      push(0, 10, "R2");
      wr(3'd1, 8'd5);
      wr(3'd0, 8'h01);
      drain();

      // R5, R6: base 3, timer 1 reload 2, timer 2 reload 4
      do_reset(4'd1);
      push(1, 12, "R5");
      push(1, 12, "R5");
      push(2, 24, "R6");
      push(2, 24, "R6");
      wr(3'd3, 8'd3);
      wr(3'd4, 8'h20);
      wr(3'd5, 8'd4);
      wr(3'd6, 8'h00);
      wr(3'd0, 8'h0E);
      drain();

      // R4: base reload {1,0x02}=258, timer 1 reload 1
      do_reset(4'd1);
      push(1, 258 * 2, "R4");
      push(1, 258 * 2, "R4");
      wr(3'd3, 8'h02);
      wr(3'd4, 8'h11);
      wr(3'd0, 8'h0A);
      drain();

      // R7: timer 1 reload 0 -> 16 base expiries of 2 ticks
      do_reset(4'd1);
      push(1, 16 * 2 * 2, "R7");
      push(1, 16 * 2 * 2, "R7");
      wr(3'd3, 8'h02);
      wr(3'd4, 8'h00);
      wr(3'd0, 8'h0A);
      drain();

      // R7: base reload 0 -> 512 ticks per base expiry
      do_reset(4'd1);
      push(1, 512 * 2, "R7");
      wr(3'd3, 8'h00);
      wr(3'd4, 8'h10);
      wr(3'd0, 8'h0A);
      drain();

      // R8: timer 1 runs but base prescaler stopped
      do_reset(4'd1);
      wr(3'd3, 8'd1);
      wr(3'd4, 8'h10);
      wr(3'd0, 8'h02);
      repeat (3000) @(negedge clk);
      check(rises[1] == 0, "R8", "timer 1 expiries with base stopped", rises[1], 0);

      // R9, R10, R11: manual status handling
      do_reset(4'd1);
      auto_clr = 1'b0;
      wr(3'd1, 8'd5);
      wr(3'd0, 8'h11);
      while (!stat[4]) @(negedge clk);
      e = cyc;
      check(irq == 1'b0, "R9", "irq with timer 0 masked", irq, 0);
      wr(3'd0, 8'h61);
      check(irq == 1'b1, "R9", "irq after unmasking timer 0", irq, 1);
      @(negedge clk);
      man_rd = 1'b1;
      check(stat == 8'h10, "R10", "status value on read", stat, 8'h10);
      @(negedge clk);
      man_rd = 1'b0;
      check(stat == 8'h00, "R10", "status after read", stat, 0);
      check(irq == 1'b0, "R10", "irq after read", irq, 0);
      t = e + 20;
      while (cyc < t - 2) @(negedge clk);
      man_rd = 1'b1;
      @(negedge clk);
      check(stat == 8'h00, "R10", "status cleared before race", stat, 0);
      @(negedge clk);
      man_rd = 1'b0;
      check(stat == 8'h10, "R11", "flag kept on read-expiry race", stat, 8'h10);
      check(irq == 1'b1, "R11", "irq kept on read-expiry race", irq, 1);
      auto_clr = 1'b1;

      finish_run();
   end

endmodule